// File: doc/BRIEF.md
# Dual-Strobe Reversible Counter with Chainable Carry and Borrow

This block is a binary counter that moves in either direction. Each direction has its own strobe input. A rising edge on the up strobe increments the count and a rising edge on the down strobe decrements it. A single fast system clock samples both strobes through synchronizer chains and finds their rising edges by comparing consecutive samples, so the strobes may be slow and unrelated to the clock.

A clear input forces the count to zero. An active-low load input copies a preset word into the count. Both are level controls, sampled on every system clock, and they take priority over counting.

The active-low carry output copies the up strobe's low phase while the count is at its maximum. The active-low borrow output copies the down strobe's low phase while the count is zero. Because of this, the carry and borrow of one instance can drive the up and down strobes of the next instance directly, which builds a wider counter. The strobes are plain level signals and have no valid/ready handshake. Every pin is a control or status pin, so the block applies no back-pressure.

Top module: `udc_counter`

## Requirements
- R1: A rising edge on `up_strobe` while `down_strobe` is high adds one to `count` within four system clocks, and the count wraps from the maximum (all ones) to zero.
- R2: A rising edge on `down_strobe` while `up_strobe` is high subtracts one from `count` within four system clocks, and the count wraps from zero to all ones.
- R3: While `clear` is high, `count` becomes zero on the next system clock, whatever the strobes and `load_n` are doing.
- R4: While `load_n` is low and `clear` is low, `count` takes the value of `preset` on the next system clock, whatever the strobes are doing. A strobe rising edge that falls inside the load window is not counted.
- R5: `carry_n` is low exactly while `count` is all ones and the sampled up strobe is low. Otherwise it is high.
- R6: `borrow_n` is low exactly while `count` is zero and the sampled down strobe is low. Otherwise it is high.
- R7: If a strobe is held low through a load or a clear and rises after the release, that rising edge is counted.
- R8: If both strobes show a rising edge in the same system clock cycle, `count` is left unchanged.
- R9: A rising edge on one strobe while the other strobe is low leaves `count` unchanged.
- R10: Two instances chained carry-to-up and borrow-to-down behave as one counter of twice the width, with the low instance's count as the low half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every input |
| clear | input | 1 | Forces the count to zero while high, highest priority |
| load_n | input | 1 | Active-low preset load, below clear in priority |
| preset | input | WIDTH | Value copied into the count during a load |
| up_strobe | input | 1 | Count-up strobe, acts on its rising edge |
| down_strobe | input | 1 | Count-down strobe, acts on its rising edge |
| count | output | WIDTH | Current count value |
| carry_n | output | 1 | Active-low carry: low at maximum while the up strobe is low |
| borrow_n | output | 1 | Active-low borrow: low at zero while the down strobe is low |

## Verification
Two pairs of events can fall into the same system clock cycle. The first pair is a strobe edge and a load: the bench raises a strobe while `load_n` is held low and expects `count` to stay at the preset value, not preset plus one. It then holds a strobe low through a load and expects the rising edge after release to be counted. The second pair is the two strobes themselves: the bench lowers both and raises both on the same clock, so their edges leave the synchronizers together, and it expects `count` not to move.

// File: rtl/udc_pkg.sv
package udc_pkg;

  typedef enum logic [2:0] {
    STEP_HOLD,
    STEP_INC,
    STEP_DEC,
    STEP_LOAD,
    STEP_CLR
  } step_e;

endpackage

// File: rtl/udc_strobe_sync.sv
module udc_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic strobe_in,
  output logic level,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= strobe_in;
      end else begin : g_next
        always_ff @(posedge clk) chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) prev <= chain[STAGES-1];

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/udc_step_decode.sv
module udc_step_decode
  import udc_pkg::*;
(
  input  logic  clear,
  input  logic  load_n,
  input  logic  up_level,
  input  logic  up_rise,
  input  logic  dn_level,
  input  logic  dn_rise,
  output step_e step
);

  always_comb begin
    if (clear)
      step = STEP_CLR;
    else if (!load_n)
      step = STEP_LOAD;
    else if (up_rise && !dn_rise && dn_level)
      step = STEP_INC;
    else if (dn_rise && !up_rise && up_level)
      step = STEP_DEC;
    else
      step = STEP_HOLD;
  end

endmodule

// File: rtl/udc_count_core.sv
module udc_count_core
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  step_e            step,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] value
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk) begin
    case (step)
      STEP_CLR:  value <= '0;
      STEP_LOAD: value <= preset;
      STEP_INC:  value <= value + ONE;
      STEP_DEC:  value <= value - ONE;
      default:   value <= value;
    endcase
  end

endmodule

// File: rtl/udc_terminal.sv
module udc_terminal #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] value,
  input  logic             up_level,
  input  logic             dn_level,
  output logic             carry_n,
  output logic             borrow_n
);

  localparam logic [WIDTH-1:0] TOP = '1;

  assign carry_n  = ~((value == TOP) & ~up_level);
  assign borrow_n = ~((value == '0) & ~dn_level);

endmodule

// File: rtl/udc_counter.sv
module udc_counter
  import udc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             up_strobe,
  input  logic             down_strobe,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);

  logic  up_level, up_rise;
  logic  dn_level, dn_rise;
  step_e step;

  udc_strobe_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .strobe_in(up_strobe), .level(up_level), .rise(up_rise)
  );

  udc_strobe_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .strobe_in(down_strobe), .level(dn_level), .rise(dn_rise)
  );

  udc_step_decode u_decode (
    .clear(clear), .load_n(load_n),
    .up_level(up_level), .up_rise(up_rise),
    .dn_level(dn_level), .dn_rise(dn_rise),
    .step(step)
  );

  udc_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .step(step), .preset(preset), .value(count)
  );

  udc_terminal #(.WIDTH(WIDTH)) u_term (
    .value(count), .up_level(up_level), .dn_level(dn_level),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );

endmodule

// File: rtl/udc_counter_chk.sv
module udc_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clear,
  input logic             load_n,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] count,
  input logic             carry_n,
  input logic             borrow_n,
  input logic             up_rise,
  input logic             dn_rise
);

  localparam logic [WIDTH-1:0] TOP = '1;

  AST_CLEAR_ZERO: assert property (@(posedge clk) clear |=> count == '0); // R3

  AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (clear)
    !load_n |=> count == $past(preset)); // R4

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (clear)
    load_n |=> (count == $past(count)) ||
               (count == WIDTH'($past(count) + 1'b1)) ||
               (count == WIDTH'($past(count) - 1'b1))); // R1

  AST_BOTH_EDGES_HOLD: assert property (@(posedge clk) disable iff (clear)
    (load_n && up_rise && dn_rise) |=> $stable(count)); // R8

  AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (clear)
    !carry_n |-> count == TOP); // R5

  AST_BORROW_AT_ZERO: assert property (@(posedge clk) disable iff (clear)
    !borrow_n |-> count == '0); // R6

endmodule

bind udc_counter udc_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .clear(clear), .load_n(load_n), .preset(preset),
  .count(count), .carry_n(carry_n), .borrow_n(borrow_n),
  .up_rise(up_rise), .dn_rise(dn_rise)
);

// File: tb/udc_counter_test.sv
module udc_counter_test;
  localparam int W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         clear = 1'b1;
  logic         load_n = 1'b1;
  logic         load_hi_n = 1'b1;
  logic [W-1:0] preset = '0;
  logic         up = 1'b1;
  logic         dn = 1'b1;
  logic [W-1:0] q_lo, q_hi;
  logic         c_lo, b_lo, c_hi, b_hi;

  udc_counter #(.WIDTH(W)) uut (
    .clk(clk), .clear(clear), .load_n(load_n), .preset(preset),
    .up_strobe(up), .down_strobe(dn),
    .count(q_lo), .carry_n(c_lo), .borrow_n(b_lo)
  );

  udc_counter #(.WIDTH(W)) uut_hi (
    .clk(clk), .clear(clear), .load_n(load_hi_n), .preset(preset),
    .up_strobe(c_lo), .down_strobe(b_lo),
    .count(q_hi), .carry_n(c_hi), .borrow_n(b_hi)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int exp;
    int ref8;
    ticks(10);
    check("R3 reset count", q_lo, 0);
    check("R5 reset carry", c_lo, 1);
    check("R6 reset borrow", b_lo, 1);
    clear = 1'b0;
    ticks(4);

    exp = 0;
    for (int i = 0; i < 20; i++) begin
      up = 1'b0; ticks(5);
      check("R5 carry while up low", c_lo, (exp == 15) ? 0 : 1);
      up = 1'b1; ticks(8);
      exp = (exp + 1) % 16;
      check("R1 up sweep", q_lo, exp);
      check("R5 carry while up high", c_lo, 1);
    end

    for (int i = 0; i < 20; i++) begin
      dn = 1'b0; ticks(5);
      check("R6 borrow while down low", b_lo, (exp == 0) ? 0 : 1);
      dn = 1'b1; ticks(8);
      exp = (exp + 15) % 16;
      check("R2 down sweep", q_lo, exp);
      check("R6 borrow while down high", b_lo, 1);
    end

    // R4: edge inside the load window is dropped
    up = 1'b0; ticks(6);
    preset = 4'd9; load_n = 1'b0; ticks(2);
    up = 1'b1; ticks(6);
    check("R4 load during edge", q_lo, 9);
    load_n = 1'b1; ticks(6);
    check("R4 edge in load dropped", q_lo, 9);

    // R7: strobe held low through load, counted after release
    up = 1'b0; ticks(6);
    preset = 4'd3; load_n = 1'b0; ticks(4);
    load_n = 1'b1; ticks(4);
    check("R7 loaded value", q_lo, 3);
    up = 1'b1; ticks(8);
    check("R7 edge after load", q_lo, 4);

    // R7: strobe held low through clear
    dn = 1'b0; ticks(6);
    clear = 1'b1; ticks(4);
    clear = 1'b0; ticks(4);
    check("R7 cleared value", q_lo, 0);
    dn = 1'b1; ticks(8);
    check("R7 edge after clear", q_lo, 15);

    // R3: clear beats load
    preset = 4'd7; clear = 1'b1; load_n = 1'b0; ticks(3);
    check("R3 clear over load", q_lo, 0);
    clear = 1'b0; ticks(3);
    check("R4 load after clear", q_lo, 7);
    load_n = 1'b1; ticks(2);

    // R8: both strobes rise together
    up = 1'b0; dn = 1'b0; ticks(6);
    up = 1'b1; dn = 1'b1; ticks(8);
    check("R8 both edges", q_lo, 7);

    // R9: up edge while down low is ignored
    up = 1'b0; dn = 1'b0; ticks(6);
    up = 1'b1; ticks(8);
    check("R9 up with down low", q_lo, 7);
    dn = 1'b1; ticks(8);
    check("R2 down after", q_lo, 6);

    // R6: load zero while down low
    dn = 1'b0; ticks(6);
    preset = 4'd0; load_n = 1'b0; ticks(2);
    load_n = 1'b1; ticks(2);
    check("R6 borrow after load zero", b_lo, 0);
    dn = 1'b1; ticks(8);
    check("R6 borrow release", b_lo, 1);

    // R10: two-stage cascade
    clear = 1'b1; ticks(6);
    clear = 1'b0; ticks(4);
    ref8 = 0;
    check("R10 cascade reset", {q_hi, q_lo}, 0);
    for (int i = 0; i < 300; i++) begin
      up = 1'b0; ticks(6);
      up = 1'b1; ticks(10);
      ref8 = (ref8 + 1) % 256;
      check("R10 cascade up", {q_hi, q_lo}, ref8);
    end
    for (int i = 0; i < 300; i++) begin
      dn = 1'b0; ticks(6);
      dn = 1'b1; ticks(10);
      ref8 = (ref8 + 255) % 256;
      check("R10 cascade down", {q_hi, q_lo}, ref8);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule